// File: doc/BRIEF.md
# Dual-Mode Timer Clock Prescaler

This block turns the bus clock into a count-enable tick for a free-running timer counter, and holds that counter. A mode input picks one of two dividers. With the mode input low, a 3-bit select gives a power-of-two divisor from 1 to 128. With the mode input high, an 8-bit value N gives a divisor of N+1, so every integer from 1 to 256 can be reached. The counter advances by one on every tick, rolls over from all ones to zero, and pulses an overflow output on that rollover.

A small sequencer drives the datapath. It has three states. `ST_SYNC` is entered from reset: on the first enabled cycle it loads the divider setting and moves to `ST_COUNT`. `ST_COUNT` is the running state. Each enabled cycle in it either reloads (the setting changed), ticks (the prescale phase reached the end of its period) or advances the phase. `ST_HALT` is entered from `ST_COUNT` when the enable drops, and from any state on a clear made while the enable is low. In `ST_HALT` nothing moves. On the next enabled cycle it acts exactly like `ST_COUNT` and goes there. `ST_SYNC` with the enable low stays in `ST_SYNC`. A clear with the enable high goes to `ST_COUNT`.

The tick, overflow and counter outputs are all registered. The tick and the counter step change on the same clock edge.

Top module: `tp_timebase`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `count` is 0 and `tick` and `wrap` are low. The first enabled edge after reset loads the divider setting without ticking.
- R2: With `fine_mode` = 0, the interval between ticks is 2^`coarse_sel` bus cycles (1, 2, 4, 8, 16, 32, 64 or 128).
- R3: With `fine_mode` = 1, the interval between ticks is `fine_div`+1 bus cycles (1 to 256). In this mode `coarse_sel` has no effect.
- R4: At divide-by-1 in either mode, `tick` is high on every enabled cycle after the setting has been loaded.
- R5: A change of `fine_mode`, or a change of the effective divisor, restarts the prescale phase at the edge where the change is seen. The next tick then comes one full new period after that edge. A change of an input that does not alter the effective divisor (`fine_div` in coarse mode, `coarse_sel` in fine mode) has no effect on tick timing.
- R6: `count` increases by exactly one on the edge that raises `tick`, and changes at no other time except a clear.
- R7: When `count` rolls from 0xFFFF to 0x0000, `wrap` is high for that one cycle, together with `tick`.
- R8: A high `cnt_clear` at an edge sets `count` and the prescale phase to zero and loads the current divider setting, whatever the state of `tmr_en`. `tick` and `wrap` are low after it. The first tick comes one full period after that edge.
- R9: While `tmr_en` is low, `count` and the prescale phase hold, and `tick` and `wrap` stay low. After re-enable, the period in progress finishes with its remaining cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_en | input | 1 | Timer enable; low freezes the prescaler and counter |
| fine_mode | input | 1 | 0: power-of-two divider, 1: divide by `fine_div`+1 |
| coarse_sel | input | SEL_W (3) | Power-of-two exponent used in coarse mode |
| fine_div | input | FINE_W (8) | Divisor minus one used in fine mode |
| cnt_clear | input | 1 | Synchronous clear of counter and prescale phase |
| tick | output | 1 | Count-enable pulse, one cycle per prescale period |
| count | output | CNT_W (16) | Timer counter value |
| wrap | output | 1 | One-cycle pulse when the counter rolls over to zero |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, a 3-bit select and an 8-bit fine divisor. These sizes bring the full rollover within reach, because it takes about 65,536 cycles at divide-by-1. They also bring the largest fine divisor of 256 and the largest coarse divisor of 128 within reach of measured tick intervals. A vector table measures the first and second tick intervals across both modes. Directed tests then cover a restart part-way through a period, inputs that must be ignored, a mode flip at equal divisor, a pause and resume, a clear while disabled, and the rollover.

// File: rtl/tp_pkg.sv
package tp_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_SYNC  = 2'd0,
        ST_COUNT = 2'd1,
        ST_HALT  = 2'd2
    } tp_state_e;

    // Per-cycle command from the sequencer to the datapath
    typedef enum logic [2:0] {
        ACT_HOLD    = 3'd0,
        ACT_RELOAD  = 3'd1,
        ACT_ADVANCE = 3'd2,
        ACT_TICK    = 3'd3,
        ACT_CLEAR   = 3'd4
    } tp_act_e;

endpackage

// File: rtl/tp_divsel.sv
// Maps mode, exponent and fine value onto a terminal prescale count (divisor - 1).
module tp_divsel #(
    parameter int SEL_W  = 3,
    parameter int FINE_W = 8,
    parameter int TERM_W = 8
) (
    input  logic              fine_mode,
    input  logic [SEL_W-1:0]  coarse_sel,
    input  logic [FINE_W-1:0] fine_div,
    output logic [TERM_W-1:0] term
);

    logic [TERM_W-1:0] coarse_term;

    // 2^sel - 1 is a run of sel ones from bit 0 upward
    for (genvar i = 0; i < TERM_W; i++) begin : g_mask
        assign coarse_term[i] = (32'(coarse_sel) > i);
    end

    always_comb begin
        if (fine_mode) begin
            term = TERM_W'(fine_div);
        end else begin
            term = coarse_term;
        end
    end

endmodule

// File: rtl/tp_seq.sv
// Sequencer: chooses the datapath action each cycle.
module tp_seq
    import tp_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tmr_en,
    input  logic    cnt_clear,
    input  logic    cfg_change,
    input  logic    at_term,
    output tp_act_e act
);

    tp_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SYNC;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        act     = ACT_HOLD;
        if (cnt_clear) begin
            act     = ACT_CLEAR;
            state_d = tmr_en ? ST_COUNT : ST_HALT;
        end else if (!tmr_en) begin
            state_d = (state_q == ST_SYNC) ? ST_SYNC : ST_HALT;
        end else begin
            unique case (state_q)
                ST_SYNC: begin
                    act     = ACT_RELOAD;
                    state_d = ST_COUNT;
                end
                ST_COUNT, ST_HALT: begin
                    state_d = ST_COUNT;
                    if (cfg_change) begin
                        act = ACT_RELOAD;
                    end else if (at_term) begin
                        act = ACT_TICK;
                    end else begin
                        act = ACT_ADVANCE;
                    end
                end
                default: begin
                    state_d = ST_SYNC;
                end
            endcase
        end
    end

endmodule

// File: rtl/tp_prescale.sv
// Prescale phase counter and the latched divider setting.
module tp_prescale
    import tp_pkg::*;
#(
    parameter int TERM_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tp_act_e           act,
    input  logic              fine_mode,
    input  logic [TERM_W-1:0] term,
    output logic              cfg_change,
    output logic              at_term
);

    logic [TERM_W-1:0] phase_q;
    logic [TERM_W-1:0] term_q;
    logic              mode_q;

    assign cfg_change = (mode_q != fine_mode) || (term_q != term);
    assign at_term    = (phase_q == term_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            term_q  <= '0;
            mode_q  <= 1'b0;
        end else begin
            unique case (act)
                ACT_RELOAD, ACT_CLEAR: begin
                    phase_q <= '0;
                    term_q  <= term;
                    mode_q  <= fine_mode;
                end
                ACT_TICK:    phase_q <= '0;
                ACT_ADVANCE: phase_q <= phase_q + TERM_W'(1);
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tp_count.sv
// Timer counter with registered tick and rollover pulse.
module tp_count
    import tp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tp_act_e          act,
    output logic             tick,
    output logic             wrap,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            tick  <= 1'b0;
            wrap  <= 1'b0;
        end else begin
            tick <= 1'b0;
            wrap <= 1'b0;
            unique case (act)
                ACT_CLEAR: count <= '0;
                ACT_TICK: begin
                    count <= count + CNT_W'(1);
                    tick  <= 1'b1;
                    wrap  <= (count == ALL_ONES);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tp_timebase.sv
module tp_timebase
    import tp_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int SEL_W  = 3,
    parameter int FINE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmr_en,
    input  logic              fine_mode,
    input  logic [SEL_W-1:0]  coarse_sel,
    input  logic [FINE_W-1:0] fine_div,
    input  logic              cnt_clear,
    output logic              tick,
    output logic [CNT_W-1:0]  count,
    output logic              wrap
);

    localparam int COARSE_W = (1 << SEL_W) - 1;
    localparam int TERM_W   = (FINE_W > COARSE_W) ? FINE_W : COARSE_W;

    logic [TERM_W-1:0] term;
    logic              cfg_change;
    logic              at_term;
    tp_act_e           act;

    tp_divsel #(.SEL_W(SEL_W), .FINE_W(FINE_W), .TERM_W(TERM_W)) u_divsel (
        .fine_mode  (fine_mode),
        .coarse_sel (coarse_sel),
        .fine_div   (fine_div),
        .term       (term)
    );

    tp_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tmr_en     (tmr_en),
        .cnt_clear  (cnt_clear),
        .cfg_change (cfg_change),
        .at_term    (at_term),
        .act        (act)
    );

    tp_prescale #(.TERM_W(TERM_W)) u_prescale (
        .clk        (clk),
        .rst_n      (rst_n),
        .act        (act),
        .fine_mode  (fine_mode),
        .term       (term),
        .cfg_change (cfg_change),
        .at_term    (at_term)
    );

    tp_count #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (act),
        .tick  (tick),
        .wrap  (wrap),
        .count (count)
    );

endmodule

// File: rtl/tp_timebase_chk.sv
module tp_timebase_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tmr_en,
    input logic             cnt_clear,
    input logic             tick,
    input logic             wrap,
    input logic [CNT_W-1:0] count
);

    assert_tick_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (count == CNT_W'($past(count) + 1'b1)));

    assert_count_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> (tick || $past(cnt_clear)));

    assert_wrap_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> (tick && count == '0));

    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clear |=> (count == '0 && !tick && !wrap));

    assert_hold_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_en && !cnt_clear) |=> ($stable(count) && !tick && !wrap));

    assert_tick_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(tmr_en && !cnt_clear));

endmodule

bind tp_timebase tp_timebase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tmr_en    (tmr_en),
    .cnt_clear (cnt_clear),
    .tick      (tick),
    .wrap      (wrap),
    .count     (count)
);

// File: tb/tp_timebase_test.sv
`timescale 1ns/1ps
module tp_timebase_test;

    localparam int CNT_W = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tmr_en = 1'b0;
    logic        fine_mode = 1'b0;
    logic [2:0]  coarse_sel = 3'd0;
    logic [7:0]  fine_div = 8'd0;
    logic        cnt_clear = 1'b0;
    logic        tick;
    logic [15:0] count;
    logic        wrap;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    tp_timebase uut (
        .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .fine_mode(fine_mode),
        .coarse_sel(coarse_sel), .fine_div(fine_div), .cnt_clear(cnt_clear),
        .tick(tick), .count(count), .wrap(wrap)
    );

    // {fine_mode, coarse_sel, fine_div, expected period}
    localparam int NV = 9;
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 3'd0, 8'd0,   9'd1},    // R2 R4
        {1'b0, 3'd1, 8'd9,   9'd2},    // R2
        {1'b0, 3'd3, 8'd200, 9'd8},    // R2
        {1'b0, 3'd7, 8'd0,   9'd128},  // R2
        {1'b1, 3'd5, 8'd0,   9'd1},    // R3 R4
        {1'b1, 3'd0, 8'd2,   9'd3},    // R3
        {1'b1, 3'd7, 8'd4,   9'd5},    // R3
        {1'b1, 3'd2, 8'd99,  9'd100},  // R3
        {1'b1, 3'd1, 8'd255, 9'd256}   // R3
    };

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Counts falling edges until tick is seen
    task automatic wait_tick(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick && n < 400);
    endtask

    task automatic steps(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    task automatic do_clear(input logic fm, input logic [2:0] sel, input logic [7:0] fd);
        fine_mode  = fm;
        coarse_sel = sel;
        fine_div   = fd;
        cnt_clear  = 1'b1;
        @(negedge clk);
        cnt_clear  = 1'b0;
        check("R8 clear count", count, 0);
        check("R8 clear tick", tick, 0);
    endtask

    initial begin
        #(4.0 * 200000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        // R1 reset
        steps(2);
        check("R1 reset count", count, 0);
        check("R1 reset tick", tick, 0);
        check("R1 reset wrap", wrap, 0);
        tmr_en = 1'b1;
        rst_n  = 1'b1;
        @(negedge clk);
        check("R1 load edge tick", tick, 0);
        check("R1 load edge count", count, 0);
        @(negedge clk);
        check("R4 first tick", tick, 1);
        check("R4 count after tick", count, 1);

        // Vector table: first and second intervals
        for (int v = 0; v < NV; v++) begin
            do_clear(VEC[v][20], VEC[v][19:17], VEC[v][16:9]);
            wait_tick(n);
            check("R2/R3 first interval", n, VEC[v][8:0]);
            check("R6 count at first tick", count, 1);
            wait_tick(n);
            check("R2/R3 second interval", n, VEC[v][8:0]);
            check("R6 count at second tick", count, 2);
        end

        // R5 restart on divisor change part-way through a period
        do_clear(1'b0, 3'd3, 8'd0);
        wait_tick(n);
        steps(3);
        coarse_sel = 3'd2;
        wait_tick(n);
        check("R5 restart interval", n, 5);
        wait_tick(n);
        check("R5 new period", n, 4);

        // R5 fine_div ignored in coarse mode
        do_clear(1'b0, 3'd3, 8'd0);
        wait_tick(n);
        steps(3);
        fine_div = 8'd77;
        wait_tick(n);
        check("R5 fine_div ignored", n, 5);

        // R5/R3 coarse_sel ignored in fine mode
        do_clear(1'b1, 3'd0, 8'd3);
        wait_tick(n);
        steps(1);
        coarse_sel = 3'd6;
        wait_tick(n);
        check("R3 coarse_sel ignored", n, 3);

        // R5 mode flip at equal divisor restarts
        do_clear(1'b0, 3'd0, 8'd0);
        wait_tick(n);
        fine_mode = 1'b1;
        wait_tick(n);
        check("R5 mode flip restart", n, 2);

        // R9 pause and resume
        do_clear(1'b0, 3'd3, 8'd0);
        wait_tick(n);
        steps(3);
        tmr_en = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check("R9 hold tick", tick, 0);
            check("R9 hold count", count, 1);
        end
        tmr_en = 1'b1;
        wait_tick(n);
        check("R9 resume remainder", n, 5);
        check("R9 count after resume", count, 2);

        // R8 clear while disabled
        tmr_en = 1'b0;
        do_clear(1'b0, 3'd0, 8'd0);
        @(negedge clk);
        check("R8 disabled clear holds zero", count, 0);
        tmr_en = 1'b1;

        // R7 rollover at divide-by-1
        do_clear(1'b0, 3'd0, 8'd0);
        steps(65535);
        check("R7 count at top", count, 16'hFFFF);
        check("R7 no wrap yet", wrap, 0);
        @(negedge clk);
        check("R7 count rolled", count, 0);
        check("R7 wrap pulse", wrap, 1);
        check("R7 tick with wrap", tick, 1);
        @(negedge clk);
        check("R7 wrap one cycle", wrap, 0);
        check("R7 count after roll", count, 1);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule